// File: doc/BRIEF.md
# Bitmap Chunk Allocator

This block keeps track of which chunks of a memory region are taken, one bit per chunk, and handles requests to claim and to release them. Bit i of the occupancy map stands for chunk i. A clear bit means the chunk is available and a set bit means it is taken. An allocation request gives a length in chunks and a placement policy. The engine walks the map one chunk per clock, looking for a run of adjacent free chunks that is long enough. It marks the chosen run as taken and returns the index of its first chunk. If no run qualifies, it reports a failure and the map is not changed.

A release request gives a start index and a length. The engine clears the whole range in a single cycle.

Four placement policies are supported:
- **First fit** takes the lowest-indexed run that fits.
- **Next fit** starts its walk just after the last chunk of the most recent successful allocation, and wraps past the top chunk back to chunk 0.
- **Best fit** walks the whole map and takes the tightest run that fits.
- **Worst fit** walks the whole map and takes the roomiest run.

Requests enter through a valid/ready handshake. Each request gets exactly one response, as a one-cycle done pulse carrying a fail flag and an index.

Top module: `chunk_alloc_engine`

## Requirements
- R1: After reset every chunk is free, `req_ready` is high, `rsp_done` is low, and the next-fit resume position is chunk 0.
- R2: An allocation uses `req_free`=0. When it succeeds, it sets map bits index through index+len-1 (a set bit means taken) and returns that index with `rsp_fail`=0.
- R3: First fit (`req_mode`=0) returns the lowest-indexed run of at least len free chunks.
- R4: Next fit (`req_mode`=1) begins its walk at the chunk after the last chunk of the most recent successful allocation of any mode. The walk wraps from chunk N-1 to chunk 0 and gives up after N positions. A free run never spans the wrap, and a failed allocation leaves the resume position unchanged.
- R5: Best fit (`req_mode`=2) returns the start of the shortest free run whose length is at least len. On a tie in length, the lower index wins.
- R6: Worst fit (`req_mode`=3) returns the start of the longest free run whose length is at least len. On a tie in length, the lower index wins.
- R7: When no run qualifies, the response has `rsp_fail`=1 and `rsp_index`=0, and the map is unchanged.
- R8: An allocation with len 0 or len greater than N is rejected with a fail response after a single edge, without walking the map.
- R9: A release uses `req_free`=1. It clears chunks start through start+len-1, and its response appears after the accepting edge. A release with len 0, or one that would run past chunk N-1, fails and changes nothing.
- R10: While a walk is in progress `req_ready` stays low. Counting the accepting edge as edge 1, the response to a walk that ends after examining position p (counted from where the walk started) appears after edge p+2. First and next fit end on the last chunk of the run they take. Best and worst fit always examine all N chunks, so they respond after edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_free | input | 1 | 0: allocate, 1: release |
| req_mode | input | 2 | Placement policy: 0 first, 1 next, 2 best, 3 worst |
| req_start | input | 6 | First chunk of a release |
| req_len | input | 7 | Length in chunks |
| rsp_done | output | 1 | One-cycle response pulse |
| rsp_fail | output | 1 | Request could not be served |
| rsp_index | output | 6 | First chunk of the run taken or released, 0 on failure |

## Verification
The bench builds the engine with its default of 64 chunks. At that size the whole map can be filled, freed at its top edge and refilled within a few hundred cycles. This puts within reach:
- a next-fit walk that has to wrap from chunk 63 to chunk 0;
- a run that closes at the map's end;
- the exact boundary between a 40-chunk run that fits and a 41-chunk request that fails;
- releases and lengths just past the last chunk (start 60 with length 5, and length 65).

At this size the full 65-edge latency of best and worst fit can be measured directly.

// File: rtl/chunk_alloc_pkg.sv
package chunk_alloc_pkg;

  typedef enum logic [1:0] {
    FIT_FIRST = 2'd0,
    FIT_NEXT  = 2'd1,
    FIT_BEST  = 2'd2,
    FIT_WORST = 2'd3
  } fit_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } eng_state_e;

endpackage

// File: rtl/chunk_map.sv
module chunk_map #(
  parameter int N  = 64,
  parameter int IW = 6,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [IW-1:0] span_start,
  input  logic [LW-1:0] span_len,
  output logic [N-1:0]  map_q
);

  // one bit per chunk inside [s, s+l)
  function automatic logic [N-1:0] span_mask(input logic [IW-1:0] s, input logic [LW-1:0] l);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) begin
      m[i] = (i >= int'(s)) && (i < int'(s) + int'(l));
    end
    return m;
  endfunction

  logic [N-1:0] mask;
  assign mask = span_mask(span_start, span_len);

  always_ff @(posedge clk) begin
    if (!rst_n)      map_q <= '0;
    else if (set_en) map_q <= map_q | mask;
    else if (clr_en) map_q <= map_q & ~mask;
  end

endmodule

// File: rtl/run_tracker.sv
module run_tracker #(
  parameter int N  = 64,
  parameter int IW = 6,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          bit_free,
  input  logic [IW-1:0] pos,
  input  logic          prefer_small,
  input  logic [LW-1:0] need,
  output logic          fit_now,
  output logic [IW-1:0] fit_start,
  output logic          pick_valid,
  output logic [IW-1:0] pick_start
);

  localparam logic [IW-1:0] TOP = IW'(N - 1);

  logic [LW-1:0] run_len, cand_len, cur_len, eval_len;
  logic [IW-1:0] run_start, cand_start, cur_start, eval_start;
  logic          cand_v, at_top, closing, fits, beats;

  always_comb begin
    at_top     = (pos == TOP);
    cur_len    = bit_free ? run_len + 1'b1 : '0;
    cur_start  = (run_len == '0) ? pos : run_start;
    closing    = !bit_free || at_top;
    eval_len   = bit_free ? cur_len : run_len;
    eval_start = bit_free ? cur_start : run_start;
    fits       = closing && (eval_len != '0) && (eval_len >= need);
    beats      = fits && (!cand_v ||
                 (prefer_small ? (eval_len < cand_len) : (eval_len > cand_len)));
    fit_now    = bit_free && (cur_len >= need);
    fit_start  = cur_start;
    pick_valid = cand_v || beats;
    pick_start = beats ? eval_start : cand_start;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      run_len    <= '0;
      run_start  <= '0;
      cand_v     <= 1'b0;
      cand_len   <= '0;
      cand_start <= '0;
    end else if (step) begin
      // a run never continues across the wrap
      run_len <= (bit_free && !at_top) ? cur_len : '0;
      if (bit_free) run_start <= cur_start;
      if (beats) begin
        cand_v     <= 1'b1;
        cand_len   <= eval_len;
        cand_start <= eval_start;
      end
    end
  end

endmodule

// File: rtl/chunk_alloc_engine.sv
module chunk_alloc_engine #(
  parameter int NUM_CHUNKS = 64,
  localparam int IW = $clog2(NUM_CHUNKS),
  localparam int LW = $clog2(NUM_CHUNKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_free,
  input  logic [1:0]    req_mode,
  input  logic [IW-1:0] req_start,
  input  logic [LW-1:0] req_len,
  output logic          rsp_done,
  output logic          rsp_fail,
  output logic [IW-1:0] rsp_index
);
  import chunk_alloc_pkg::*;

  localparam logic [IW-1:0] TOP   = IW'(NUM_CHUNKS - 1);
  localparam logic [LW-1:0] N_LEN = LW'(NUM_CHUNKS);

  function automatic logic overruns(input logic [IW-1:0] s, input logic [LW-1:0] l);
    return (int'(s) + int'(l)) > NUM_CHUNKS;
  endfunction

  function automatic logic [IW-1:0] wrap_after(input logic [IW-1:0] s, input logic [LW-1:0] l);
    int sum;
    sum = int'(s) + int'(l);
    if (sum >= NUM_CHUNKS) sum = sum - NUM_CHUNKS;
    return IW'(sum);
  endfunction

  eng_state_e    state;
  fit_mode_e     mode_q;
  logic [LW-1:0] len_q;
  logic [IW-1:0] scan_pos, scan_cnt, resume_ptr;
  logic          rsp_op_free;

  // named events
  logic [NUM_CHUNKS-1:0] chunk_state;
  logic accept, scanning, len_bad, free_bad, free_ok, greedy, scan_last;
  logic bit_free, fit_now, pick_valid, hit_greedy, hit_sized, alloc_win, scan_miss;
  logic [IW-1:0] fit_start, pick_start, win_start, map_start;
  logic [LW-1:0] map_len;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign scanning   = (state == ST_SCAN);
  assign len_bad    = (req_len == '0) || (req_len > N_LEN);
  assign free_bad   = (req_len == '0) || overruns(req_start, req_len);
  assign free_ok    = accept && req_free && !free_bad;
  assign greedy     = (mode_q == FIT_FIRST) || (mode_q == FIT_NEXT);
  assign scan_last  = (scan_cnt == TOP);
  assign bit_free   = !chunk_state[scan_pos];
  assign hit_greedy = scanning && greedy && fit_now;
  assign hit_sized  = scanning && !greedy && scan_last && pick_valid;
  assign alloc_win  = hit_greedy || hit_sized;
  assign win_start  = hit_greedy ? fit_start : pick_start;
  assign scan_miss  = scanning && scan_last && !alloc_win;
  assign map_start  = alloc_win ? win_start : req_start;
  assign map_len    = alloc_win ? len_q : req_len;

  chunk_map #(.N(NUM_CHUNKS), .IW(IW), .LW(LW)) u_map (
    .clk(clk), .rst_n(rst_n), .set_en(alloc_win), .clr_en(free_ok),
    .span_start(map_start), .span_len(map_len), .map_q(chunk_state)
  );

  run_tracker #(.N(NUM_CHUNKS), .IW(IW), .LW(LW)) u_runs (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step(scanning),
    .bit_free(bit_free), .pos(scan_pos), .prefer_small(mode_q == FIT_BEST),
    .need(len_q), .fit_now(fit_now), .fit_start(fit_start),
    .pick_valid(pick_valid), .pick_start(pick_start)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mode_q      <= FIT_FIRST;
      len_q       <= '0;
      scan_pos    <= '0;
      scan_cnt    <= '0;
      resume_ptr  <= '0;
      rsp_op_free <= 1'b0;
      rsp_done    <= 1'b0;
      rsp_fail    <= 1'b0;
      rsp_index   <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_fail <= 1'b0;
      if (accept) begin
        rsp_op_free <= req_free;
        if (req_free) begin
          rsp_done  <= 1'b1;
          rsp_fail  <= free_bad;
          rsp_index <= free_bad ? '0 : req_start;
        end else if (len_bad) begin
          rsp_done  <= 1'b1;
          rsp_fail  <= 1'b1;
          rsp_index <= '0;
        end else begin
          state    <= ST_SCAN;
          mode_q   <= fit_mode_e'(req_mode);
          len_q    <= req_len;
          scan_pos <= (fit_mode_e'(req_mode) == FIT_NEXT) ? resume_ptr : '0;
          scan_cnt <= '0;
        end
      end else if (scanning) begin
        if (alloc_win) begin
          state      <= ST_IDLE;
          rsp_done   <= 1'b1;
          rsp_index  <= win_start;
          resume_ptr <= wrap_after(win_start, len_q);
        end else if (scan_miss) begin
          state     <= ST_IDLE;
          rsp_done  <= 1'b1;
          rsp_fail  <= 1'b1;
          rsp_index <= '0;
        end else begin
          scan_pos <= (scan_pos == TOP) ? '0 : scan_pos + 1'b1;
          scan_cnt <= scan_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/chunk_alloc_engine_chk.sv
module chunk_alloc_engine_chk #(
  parameter int N  = 64,
  parameter int IW = 6,
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_free,
  input logic [LW-1:0] req_len,
  input logic          rsp_done,
  input logic          rsp_fail,
  input logic [IW-1:0] rsp_index,
  input logic          rsp_op_free,
  input logic [N-1:0]  chunk_state
);

  // R7
  fail_keeps_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fail |-> (chunk_state == $past(chunk_state)));

  // R7
  fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fail |-> rsp_done);

  // R2
  alloc_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_fail && !rsp_op_free) |-> chunk_state[rsp_index]);

  // R9
  free_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_fail && rsp_op_free) |-> !chunk_state[rsp_index]);

  // R10
  busy_while_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_free && req_len != '0 && req_len <= LW'(N))
      |=> !req_ready);

endmodule

bind chunk_alloc_engine chunk_alloc_engine_chk #(.N(NUM_CHUNKS), .IW(IW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_free(req_free), .req_len(req_len), .rsp_done(rsp_done),
  .rsp_fail(rsp_fail), .rsp_index(rsp_index), .rsp_op_free(rsp_op_free),
  .chunk_state(chunk_state)
);

// File: tb/sim_chunk_alloc_engine.sv
`timescale 1ns/1ps
module sim_chunk_alloc_engine;

  localparam int NC = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_free = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic [5:0] req_start = '0;
  logic [6:0] req_len = '0;
  logic       rsp_done, rsp_fail;
  logic [5:0] rsp_index;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  chunk_alloc_engine #(.NUM_CHUNKS(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_free(req_free), .req_mode(req_mode), .req_start(req_start),
    .req_len(req_len), .rsp_done(rsp_done), .rsp_fail(rsp_fail),
    .rsp_index(rsp_index)
  );

  typedef struct packed {
    logic       fr;
    logic [1:0] md;
    logic [5:0] st;
    logic [6:0] ln;
    logic       xf;
    logic [5:0] xi;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0,  6'd0,  7'd4, 1'b0,  6'd0, 4'd3},  // R3 empty map
    '{1'b0, 2'd0,  6'd0,  7'd8, 1'b0,  6'd4, 4'd3},  // R3
    '{1'b0, 2'd0,  6'd0,  7'd2, 1'b0, 6'd12, 4'd2},  // R2
    '{1'b1, 2'd0,  6'd4,  7'd8, 1'b0,  6'd4, 4'd9},  // R9 release 4..11
    '{1'b0, 2'd2,  6'd0,  7'd3, 1'b0,  6'd4, 4'd5},  // R5 runs 8 and 50
    '{1'b0, 2'd3,  6'd0,  7'd5, 1'b0, 6'd14, 4'd6},  // R6 runs 5 and 50
    '{1'b0, 2'd1,  6'd0,  7'd5, 1'b0, 6'd19, 4'd4},  // R4 resumes at 19
    '{1'b0, 2'd0,  6'd0,  7'd5, 1'b0,  6'd7, 4'd3},  // R3 fills hole 7..11
    '{1'b0, 2'd1,  6'd0, 7'd41, 1'b1,  6'd0, 4'd7},  // R7 largest run is 40
    '{1'b0, 2'd0,  6'd0, 7'd40, 1'b0, 6'd24, 4'd7},  // R7 map intact after miss
    '{1'b0, 2'd2,  6'd0,  7'd1, 1'b1,  6'd0, 4'd7},  // R7 full map
    '{1'b1, 2'd0, 6'd60,  7'd5, 1'b1,  6'd0, 4'd9},  // R9 past top
    '{1'b1, 2'd0, 6'd60,  7'd4, 1'b0, 6'd60, 4'd9},  // R9 up to top
    '{1'b0, 2'd1,  6'd0,  7'd1, 1'b0, 6'd60, 4'd4},  // R4 resume ptr 0
    '{1'b1, 2'd0,  6'd0,  7'd4, 1'b0,  6'd0, 4'd9},  // R9
    '{1'b0, 2'd1,  6'd0,  7'd4, 1'b0,  6'd0, 4'd4},  // R4 wrap, 61..63 too short
    '{1'b0, 2'd0,  6'd0,  7'd0, 1'b1,  6'd0, 4'd8},  // R8 zero length
    '{1'b0, 2'd0,  6'd0, 7'd65, 1'b1,  6'd0, 4'd8},  // R8 longer than map
    '{1'b1, 2'd0,  6'd0,  7'd0, 1'b1,  6'd0, 4'd9},  // R9 zero length
    '{1'b0, 2'd3,  6'd0,  7'd2, 1'b0, 6'd61, 4'd6},  // R6 run at top end
    '{1'b0, 2'd2,  6'd0,  7'd1, 1'b0, 6'd63, 4'd5},  // R5 last chunk
    '{1'b1, 2'd0, 6'd10,  7'd2, 1'b0, 6'd10, 4'd9},  // R9
    '{1'b1, 2'd0, 6'd30,  7'd2, 1'b0, 6'd30, 4'd9},  // R9
    '{1'b0, 2'd2,  6'd0,  7'd2, 1'b0, 6'd10, 4'd5},  // R5 tie, lower wins
    '{1'b0, 2'd3,  6'd0,  7'd1, 1'b0, 6'd30, 4'd6}   // R6
  };

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic fr, input logic [1:0] md, input logic [5:0] st,
                       input logic [6:0] ln, output logic f, output int idx,
                       output int lat, output logic busy_seen);
    @(negedge clk);
    req_valid = 1'b1; req_free = fr; req_mode = md; req_start = st; req_len = ln;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    busy_seen = !req_ready;
    while (!rsp_done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    f = rsp_fail;
    idx = int'(rsp_index);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic f, busy;
    int idx, lat;
    string tag;
    do_reset();
    // R1 reset state
    check_eq("R1", "req_ready", int'(req_ready), 1);
    check_eq("R1", "rsp_done", int'(rsp_done), 0);

    for (int v = 0; v < NV; v++) begin
      issue(VEC[v].fr, VEC[v].md, VEC[v].st, VEC[v].ln, f, idx, lat, busy);
      tag = $sformatf("R%0d", VEC[v].rq);
      check_eq(tag, $sformatf("vec %0d fail", v), int'(f), int'(VEC[v].xf));
      check_eq(tag, $sformatf("vec %0d index", v), idx, int'(VEC[v].xi));
    end

    // R1 reset clears map and resume pointer (pointer was 31)
    do_reset();
    issue(1'b0, 2'd1, 6'd0, 7'd1, f, idx, lat, busy);
    check_eq("R1", "next fit after reset index", idx, 0);
    check_eq("R10", "next fit len1 latency", lat, 2);
    // R10 first fit, chunk 0 taken: run 1..3 closes at position 3
    issue(1'b0, 2'd0, 6'd0, 7'd3, f, idx, lat, busy);
    check_eq("R3", "first fit index", idx, 1);
    check_eq("R10", "first fit latency", lat, 5);
    check_eq("R10", "ready low during walk", int'(busy), 1);
    // R10 best fit always walks all chunks
    issue(1'b0, 2'd2, 6'd0, 7'd2, f, idx, lat, busy);
    check_eq("R5", "best fit index", idx, 4);
    check_eq("R10", "best fit latency", lat, NC + 1);
    // R9 release answers after the accepting edge
    issue(1'b1, 2'd0, 6'd1, 7'd3, f, idx, lat, busy);
    check_eq("R9", "release latency", lat, 1);
    check_eq("R9", "release ready stays high", int'(busy), 0);
    // R8 rejected allocation answers at once
    issue(1'b0, 2'd3, 6'd0, 7'd0, f, idx, lat, busy);
    check_eq("R8", "reject latency", lat, 1);
    check_eq("R8", "reject fail", int'(f), 1);
    // R2 released chunks 1..3 are reusable
    issue(1'b0, 2'd0, 6'd0, 7'd3, f, idx, lat, busy);
    check_eq("R2", "reuse index", idx, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule